// File: doc/BRIEF.md
# Command executor and device-under-test bus master

This block sits between a byte receiver and a byte transmitter in a test harness for a peripheral. Once a complete command frame has been collected, the receiver presents the frame to the block as a flat byte vector with its length and pulses a valid strobe. The block checks the frame and decodes its opcode. It then carries out the command against the device under test, either on a single-cycle memory-like bus or by pulsing a dedicated reset line.

When the command finishes, the block assembles the whole response frame in one register. It pulses a start strobe so that the transmitter can send the bytes. Address and data fields travel most significant byte first, both in commands and in responses. The device's own reset output is independent of the system reset.

Top module: `cmdx_exec`

## Requirements
- R1: While `rst_n` is low, `busy`, `rsp_start`, `dev_cs`, `dev_we` and `dev_rst` are 0 and `rsp_len`/`rsp_frame` are zero. A system reset that arrives during a device reset hold drops `dev_rst` at once.
- R2: Byte i of a frame occupies bits [8i+7:8i]. Byte 0 must be 0x55, byte 1 is the opcode and the byte at index len-1 must be 0xaa. Valid frames are opcode 0x01 with length 3, 0x10 with length 5 and 0x11 with length 9. Any other frame gets no bus cycle and no device reset, and is answered with the 4 bytes 0xaa, 0xfe, opcode, 0x55.
- R3: A read (0x10) raises `dev_cs` for exactly one cycle with `dev_we` low. `dev_cs` is first seen high at the second rising edge after the edge that accepts the frame. `dev_addr` is bytes 2..3, with byte 2 as the high byte.
- R4: A write (0x11) raises `dev_we` together with `dev_cs`. `dev_wdata` is bytes 4..7, with byte 4 as the most significant byte.
- R5: A read whose error input is clear is answered with 9 bytes: 0xaa, 0x7f, the two address bytes, the four `dev_rdata` bytes (MSB first) and 0x55. The read data is sampled in the cycle after `dev_cs`.
- R6: A write whose error input is clear is answered with 5 bytes: 0xaa, 0x7e, the two address bytes and 0x55.
- R7: `dev_err` is sampled only in the cycle after `dev_cs`. When it is high, the response is the 4 bytes 0xaa, 0xfd, opcode, 0x55, for reads and for writes.
- R8: A reset command (0x01) holds `dev_rst` high for exactly RST_CYCLES consecutive cycles with no bus cycle. It is then answered with the 3 bytes 0xaa, 0x7d, 0x55.
- R9: `rsp_start` is a one-cycle pulse. `rsp_frame` and `rsp_len` are valid while it is high and hold until the next response, and bytes at index rsp_len and above are zero.
- R10: `busy` is high from the accepting edge until the response is issued. A `cmd_valid` that arrives while busy is ignored, which means no extra bus cycle and no extra response.
- R11: `dev_cs` is never high together with `dev_rst` and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low system reset |
| cmd_valid | input | 1 | frame present, accepted when idle |
| cmd_len | input | LEN_W (4) | frame length in bytes including delimiters |
| cmd_frame | input | 8*NBYTES (72) | frame bytes, byte 0 in the low bits |
| busy | output | 1 | command in progress |
| rsp_start | output | 1 | one-cycle strobe: response ready for the transmitter |
| rsp_len | output | LEN_W (4) | response length in bytes |
| rsp_frame | output | 8*NBYTES (72) | response bytes, byte 0 in the low bits |
| dev_rst | output | 1 | active-high reset to the device under test |
| dev_cs | output | 1 | bus chip select |
| dev_we | output | 1 | bus write enable |
| dev_addr | output | ADDR_W (16) | bus address |
| dev_wdata | output | DATA_W (32) | bus write data |
| dev_rdata | input | DATA_W (32) | bus read data |
| dev_err | input | 1 | device error flag |

## Verification
The bench builds the block with the default 16-bit address and 32-bit data, and overrides RST_CYCLES to 3. This makes the reset hold length a separate value from the default, so a counter that ignores the parameter is caught. With the 9-byte frame, every field position and every length mismatch can be reached by a table walk. The device model drives read data and clears its error flag only in the cycle after chip select, and shows poison values at all other times. An off-by-one sampling cycle therefore shows up as a wrong response code or wrong data bytes.

// File: rtl/cmdx_pkg.sv
package cmdx_pkg;
   localparam logic [7:0] OP_RESET    = 8'h01;
   localparam logic [7:0] OP_READ     = 8'h10;
   localparam logic [7:0] OP_WRITE    = 8'h11;
   localparam logic [7:0] RC_UNKNOWN  = 8'hfe;
   localparam logic [7:0] RC_ERROR    = 8'hfd;
   localparam logic [7:0] RC_READ_OK  = 8'h7f;
   localparam logic [7:0] RC_WRITE_OK = 8'h7e;
   localparam logic [7:0] RC_RESET_OK = 8'h7d;

   typedef enum logic [1:0] {K_UNKNOWN, K_RESET, K_READ, K_WRITE} kind_e;
   typedef enum logic [2:0] {S_IDLE, S_DECODE, S_BUS, S_HOLD, S_BUILD} state_e;
endpackage

// File: rtl/cmdx_decode.sv
module cmdx_decode
   import cmdx_pkg::*;
#(
   parameter int         ADDR_B    = 2,
   parameter int         DATA_B    = 4,
   parameter logic [7:0] CMD_OPEN  = 8'h55,
   parameter logic [7:0] CMD_CLOSE = 8'haa,
   localparam int        NBYTES    = 3 + ADDR_B + DATA_B,
   localparam int        LEN_W     = $clog2(NBYTES + 1)
) (
   input  logic [8*NBYTES-1:0] frame,
   input  logic [LEN_W-1:0]    len,
   output kind_e               kind,
   output logic [7:0]          opcode,
   output logic [8*ADDR_B-1:0] addr,
   output logic [8*DATA_B-1:0] wdata
);
   localparam int LEN_RST = 3;
   localparam int LEN_RD  = 3 + ADDR_B;
   localparam int LEN_WR  = 3 + ADDR_B + DATA_B;

   logic [7:0] last_b;
   logic       frame_ok;

   assign opcode = frame[15:8];

   for (genvar i = 0; i < ADDR_B; i++) begin : g_addr
      assign addr[(ADDR_B-1-i)*8 +: 8] = frame[(2+i)*8 +: 8];
   end
   for (genvar i = 0; i < DATA_B; i++) begin : g_data
      assign wdata[(DATA_B-1-i)*8 +: 8] = frame[(2+ADDR_B+i)*8 +: 8];
   end

   always_comb begin
      last_b = 8'h00;
      for (int i = 0; i < NBYTES; i++)
         if (len == LEN_W'(i + 1)) last_b = frame[i*8 +: 8];
   end

   always_comb begin
      frame_ok = (frame[7:0] == CMD_OPEN) && (last_b == CMD_CLOSE);
      kind     = K_UNKNOWN;
      if (frame_ok) begin
         case (opcode)
            OP_RESET: if (len == LEN_W'(LEN_RST)) kind = K_RESET;
            OP_READ:  if (len == LEN_W'(LEN_RD))  kind = K_READ;
            OP_WRITE: if (len == LEN_W'(LEN_WR))  kind = K_WRITE;
            default:  kind = K_UNKNOWN;
         endcase
      end
   end
endmodule

// File: rtl/cmdx_bus.sv
module cmdx_bus #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              go_wr,
   input  logic [ADDR_W-1:0] go_addr,
   input  logic [DATA_W-1:0] go_wdata,
   output logic              dev_cs,
   output logic              dev_we,
   output logic [ADDR_W-1:0] dev_addr,
   output logic [DATA_W-1:0] dev_wdata,
   input  logic [DATA_W-1:0] dev_rdata,
   input  logic              dev_err,
   output logic              done,
   output logic [DATA_W-1:0] rdata_q,
   output logic              err_q
);
   logic smp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_cs    <= 1'b0;
         dev_we    <= 1'b0;
         dev_addr  <= '0;
         dev_wdata <= '0;
         smp_q     <= 1'b0;
         rdata_q   <= '0;
         err_q     <= 1'b0;
      end else begin
         smp_q <= dev_cs;
         if (go) begin
            dev_cs    <= 1'b1;
            dev_we    <= go_wr;
            dev_addr  <= go_addr;
            dev_wdata <= go_wdata;
         end else begin
            dev_cs <= 1'b0;
            dev_we <= 1'b0;
         end
         if (smp_q) begin
            rdata_q <= dev_rdata;
            err_q   <= dev_err;
         end
      end
   end

   assign done = smp_q;

   p_we_needs_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dev_we |-> dev_cs);
   p_cs_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dev_cs |=> !dev_cs);
   p_sample_after_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dev_cs |=> done);
endmodule

// File: rtl/cmdx_hold.sv
module cmdx_hold #(
   parameter int CYCLES = 4,
   localparam int CW    = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic hold_o,
   output logic done
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_o <= 1'b0;
         cnt_q  <= '0;
      end else if (go) begin
         hold_o <= 1'b1;
         cnt_q  <= CW'(CYCLES - 1);
      end else if (hold_o) begin
         if (cnt_q == '0) hold_o <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign done = hold_o && (cnt_q == '0);

   // run-length counter for the hold checker
   logic [CW:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_q <= '0;
      else if (hold_o) run_q <= run_q + 1'b1;
      else             run_q <= '0;
   end

   p_hold_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_o) |-> (run_q == (CW+1)'(CYCLES)));
endmodule

// File: rtl/cmdx_rsp.sv
module cmdx_rsp
   import cmdx_pkg::*;
#(
   parameter int         ADDR_B    = 2,
   parameter int         DATA_B    = 4,
   parameter logic [7:0] RSP_OPEN  = 8'haa,
   parameter logic [7:0] RSP_CLOSE = 8'h55,
   localparam int        NBYTES    = 3 + ADDR_B + DATA_B,
   localparam int        LEN_W     = $clog2(NBYTES + 1)
) (
   input  kind_e               kind,
   input  logic                err,
   input  logic [7:0]          opcode,
   input  logic [8*ADDR_B-1:0] addr,
   input  logic [8*DATA_B-1:0] rdata,
   output logic [8*NBYTES-1:0] bytes,
   output logic [LEN_W-1:0]    len
);
   logic bus_kind;
   assign bus_kind = (kind == K_READ) || (kind == K_WRITE);

   always_comb begin
      bytes      = '0;
      bytes[7:0] = RSP_OPEN;
      len        = LEN_W'(3);
      if (kind == K_UNKNOWN || (bus_kind && err)) begin
         bytes[15:8]  = (kind == K_UNKNOWN) ? RC_UNKNOWN : RC_ERROR;
         bytes[23:16] = opcode;
         bytes[31:24] = RSP_CLOSE;
         len          = LEN_W'(4);
      end else if (kind == K_RESET) begin
         bytes[15:8]  = RC_RESET_OK;
         bytes[23:16] = RSP_CLOSE;
         len          = LEN_W'(3);
      end else begin
         bytes[15:8] = (kind == K_READ) ? RC_READ_OK : RC_WRITE_OK;
         for (int i = 0; i < ADDR_B; i++)
            bytes[(2+i)*8 +: 8] = addr[(ADDR_B-1-i)*8 +: 8];
         if (kind == K_READ) begin
            for (int i = 0; i < DATA_B; i++)
               bytes[(2+ADDR_B+i)*8 +: 8] = rdata[(DATA_B-1-i)*8 +: 8];
            bytes[(2+ADDR_B+DATA_B)*8 +: 8] = RSP_CLOSE;
            len = LEN_W'(3 + ADDR_B + DATA_B);
         end else begin
            bytes[(2+ADDR_B)*8 +: 8] = RSP_CLOSE;
            len = LEN_W'(3 + ADDR_B);
         end
      end
   end
endmodule

// File: rtl/cmdx_exec.sv
module cmdx_exec
   import cmdx_pkg::*;
#(
   parameter int         ADDR_W     = 16,
   parameter int         DATA_W     = 32,
   parameter int         RST_CYCLES = 4,
   parameter logic [7:0] CMD_OPEN   = 8'h55,
   parameter logic [7:0] CMD_CLOSE  = 8'haa,
   parameter logic [7:0] RSP_OPEN   = 8'haa,
   parameter logic [7:0] RSP_CLOSE  = 8'h55,
   localparam int        ADDR_B     = ADDR_W / 8,
   localparam int        DATA_B     = DATA_W / 8,
   localparam int        NBYTES     = 3 + ADDR_B + DATA_B,
   localparam int        LEN_W      = $clog2(NBYTES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   input  logic [LEN_W-1:0]    cmd_len,
   input  logic [8*NBYTES-1:0] cmd_frame,
   output logic                busy,
   output logic                rsp_start,
   output logic [LEN_W-1:0]    rsp_len,
   output logic [8*NBYTES-1:0] rsp_frame,
   output logic                dev_rst,
   output logic                dev_cs,
   output logic                dev_we,
   output logic [ADDR_W-1:0]   dev_addr,
   output logic [DATA_W-1:0]   dev_wdata,
   input  logic [DATA_W-1:0]   dev_rdata,
   input  logic                dev_err
);
   if (ADDR_W < 8 || ADDR_W % 8 != 0) begin : g_bad_addr
      $error("ADDR_W must be a positive multiple of 8");
   end
   if (DATA_W < 8 || DATA_W % 8 != 0) begin : g_bad_data
      $error("DATA_W must be a positive multiple of 8");
   end
   if (RST_CYCLES < 1) begin : g_bad_hold
      $error("RST_CYCLES must be at least 1");
   end

   state_e                state_q;
   logic [8*NBYTES-1:0]   frame_q;
   logic [LEN_W-1:0]      len_q;
   kind_e                 kind;
   logic [7:0]            opcode;
   logic [ADDR_W-1:0]     f_addr;
   logic [DATA_W-1:0]     f_wdata;
   logic                  bus_go, bus_done, bus_err;
   logic [DATA_W-1:0]     bus_rdata;
   logic                  hold_go, hold_done;
   logic [8*NBYTES-1:0]   rsp_bytes;
   logic [LEN_W-1:0]      rsp_n;

   cmdx_decode #(.ADDR_B(ADDR_B), .DATA_B(DATA_B),
                 .CMD_OPEN(CMD_OPEN), .CMD_CLOSE(CMD_CLOSE)) u_decode (
      .frame(frame_q), .len(len_q), .kind(kind), .opcode(opcode),
      .addr(f_addr), .wdata(f_wdata));

   assign bus_go  = (state_q == S_DECODE) && (kind == K_READ || kind == K_WRITE);
   assign hold_go = (state_q == S_DECODE) && (kind == K_RESET);

   cmdx_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
      .clk(clk), .rst_n(rst_n), .go(bus_go), .go_wr(kind == K_WRITE),
      .go_addr(f_addr), .go_wdata(f_wdata),
      .dev_cs(dev_cs), .dev_we(dev_we), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
      .dev_rdata(dev_rdata), .dev_err(dev_err),
      .done(bus_done), .rdata_q(bus_rdata), .err_q(bus_err));

   cmdx_hold #(.CYCLES(RST_CYCLES)) u_hold (
      .clk(clk), .rst_n(rst_n), .go(hold_go), .hold_o(dev_rst), .done(hold_done));

   cmdx_rsp #(.ADDR_B(ADDR_B), .DATA_B(DATA_B),
              .RSP_OPEN(RSP_OPEN), .RSP_CLOSE(RSP_CLOSE)) u_rsp (
      .kind(kind), .err(bus_err), .opcode(opcode), .addr(f_addr),
      .rdata(bus_rdata), .bytes(rsp_bytes), .len(rsp_n));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         frame_q   <= '0;
         len_q     <= '0;
         rsp_frame <= '0;
         rsp_len   <= '0;
         rsp_start <= 1'b0;
      end else begin
         rsp_start <= 1'b0;
         case (state_q)
            S_IDLE: if (cmd_valid) begin
               frame_q <= cmd_frame;
               len_q   <= cmd_len;
               state_q <= S_DECODE;
            end
            S_DECODE: begin
               case (kind)
                  K_READ, K_WRITE: state_q <= S_BUS;
                  K_RESET:         state_q <= S_HOLD;
                  default:         state_q <= S_BUILD;
               endcase
            end
            S_BUS:  if (bus_done)  state_q <= S_BUILD;
            S_HOLD: if (hold_done) state_q <= S_BUILD;
            S_BUILD: begin
               rsp_frame <= rsp_bytes;
               rsp_len   <= rsp_n;
               rsp_start <= 1'b1;
               state_q   <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy = (state_q != S_IDLE);

   p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_start |=> !rsp_start);
   p_rsp_len_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_start |-> (rsp_len == LEN_W'(3) || rsp_len == LEN_W'(4) ||
                     rsp_len == LEN_W'(3 + ADDR_B) || rsp_len == LEN_W'(NBYTES)));
   p_cs_rst_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_cs && dev_rst));
   p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid) |=> $stable(frame_q));
   p_frame_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_start |-> $stable(rsp_frame));
endmodule

// File: tb/cmdx_exec_test.sv
`timescale 1ns/1ps
module cmdx_exec_test;
   localparam int HOLD = 3;

   typedef struct packed {
      logic [3:0]  len;
      logic [71:0] frame;
      logic        err;
      logic [31:0] rdata;
      logic [3:0]  exp_len;
      logic [71:0] exp;
      logic        exp_cs;
      logic        exp_we;
      logic [15:0] exp_addr;
      logic [31:0] exp_wdata;
      logic        exp_rst;
   } vec_t;

   // frames and responses written byte 0 first (leftmost)
   localparam vec_t VECS [12] = '{
      '{4'd5, 72'h55_10_12_34_aa_00_00_00_00, 1'b0, 32'hcafef00d, 4'd9, 72'haa_7f_12_34_ca_fe_f0_0d_55, 1'b1, 1'b0, 16'h1234, 32'h0, 1'b0},
      '{4'd9, 72'h55_11_ab_cd_01_02_03_04_aa, 1'b0, 32'h0,        4'd5, 72'haa_7e_ab_cd_55_00_00_00_00, 1'b1, 1'b1, 16'habcd, 32'h01020304, 1'b0},
      '{4'd5, 72'h55_10_00_07_aa_00_00_00_00, 1'b1, 32'h12345678, 4'd4, 72'haa_fd_10_55_00_00_00_00_00, 1'b1, 1'b0, 16'h0007, 32'h0, 1'b0},
      '{4'd9, 72'h55_11_ff_fe_11_22_33_44_aa, 1'b1, 32'h0,        4'd4, 72'haa_fd_11_55_00_00_00_00_00, 1'b1, 1'b1, 16'hfffe, 32'h11223344, 1'b0},
      '{4'd3, 72'h55_42_aa_00_00_00_00_00_00, 1'b0, 32'h0,        4'd4, 72'haa_fe_42_55_00_00_00_00_00, 1'b0, 1'b0, 16'h0, 32'h0, 1'b0},
      '{4'd9, 72'h55_10_12_34_00_00_00_00_aa, 1'b0, 32'h0,        4'd4, 72'haa_fe_10_55_00_00_00_00_00, 1'b0, 1'b0, 16'h0, 32'h0, 1'b0},
      '{4'd5, 72'h55_01_00_00_aa_00_00_00_00, 1'b0, 32'h0,        4'd4, 72'haa_fe_01_55_00_00_00_00_00, 1'b0, 1'b0, 16'h0, 32'h0, 1'b0},
      '{4'd3, 72'h55_01_aa_00_00_00_00_00_00, 1'b0, 32'h0,        4'd3, 72'haa_7d_55_00_00_00_00_00_00, 1'b0, 1'b0, 16'h0, 32'h0, 1'b1},
      '{4'd5, 72'h55_10_ff_ff_aa_00_00_00_00, 1'b0, 32'h80000001, 4'd9, 72'haa_7f_ff_ff_80_00_00_01_55, 1'b1, 1'b0, 16'hffff, 32'h0, 1'b0},
      '{4'd5, 72'h55_11_ab_cd_aa_00_00_00_00, 1'b0, 32'h0,        4'd4, 72'haa_fe_11_55_00_00_00_00_00, 1'b0, 1'b0, 16'h0, 32'h0, 1'b0},
      '{4'd5, 72'h54_10_12_34_aa_00_00_00_00, 1'b0, 32'h0,        4'd4, 72'haa_fe_10_55_00_00_00_00_00, 1'b0, 1'b0, 16'h0, 32'h0, 1'b0},
      '{4'd5, 72'h55_10_12_34_ab_00_00_00_00, 1'b0, 32'h0,        4'd4, 72'haa_fe_10_55_00_00_00_00_00, 1'b0, 1'b0, 16'h0, 32'h0, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_len = '0;
   logic [71:0] cmd_frame = '0;
   logic        busy, rsp_start, dev_rst, dev_cs, dev_we, dev_err;
   logic [3:0]  rsp_len;
   logic [71:0] rsp_frame;
   logic [15:0] dev_addr;
   logic [31:0] dev_wdata, dev_rdata;

   always #10 clk = ~clk;

   cmdx_exec #(.ADDR_W(16), .DATA_W(32), .RST_CYCLES(HOLD)) uut (.*);

   // device model: real data and a clear error flag only in the cycle after chip select
   logic        resp_phase = 1'b0;
   logic [31:0] cur_rdata = '0;
   logic        cur_err = 1'b0;
   always @(posedge clk) resp_phase <= dev_cs;
   assign dev_rdata = resp_phase ? cur_rdata : 32'hdeadbeef;
   assign dev_err   = resp_phase ? cur_err : 1'b1;

   // monitors keep running totals
   int          cyc = 0, cs_total = 0, rst_total = 0, start_total = 0, cs_cyc = 0;
   logic        seen_we = 1'b0;
   logic [15:0] seen_addr = '0;
   logic [31:0] seen_wdata = '0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (dev_cs) begin
         cs_total   <= cs_total + 1;
         cs_cyc     <= cyc;
         seen_we    <= dev_we;
         seen_addr  <= dev_addr;
         seen_wdata <= dev_wdata;
      end
      if (dev_rst)   rst_total   <= rst_total + 1;
      if (rsp_start) start_total <= start_total + 1;
   end

   int n_checks = 0, n_fail = 0;

   task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [71:0] to_dut(input logic [71:0] lit);
      logic [71:0] o;
      for (int i = 0; i < 9; i++) o[i*8 +: 8] = lit[(8-i)*8 +: 8];
      return o;
   endfunction

   function automatic string tag_of(input logic [7:0] code);
      case (code)
         8'h7f:   return "R5 read ok";
         8'h7e:   return "R6 write ok";
         8'hfd:   return "R7 error";
         8'h7d:   return "R8 reset ok";
         default: return "R2 unknown";
      endcase
   endfunction

   task automatic wait_rsp();
      for (int i = 0; i < 60; i++) begin
         if (rsp_start) return;
         @(negedge clk);
      end
      n_checks++; n_fail++;
      $display("FAIL R9: actual no rsp_start expected rsp_start within 60 cycles");
   endtask

   task automatic issue(input logic [3:0] len, input logic [71:0] lit);
      cmd_frame = to_dut(lit);
      cmd_len   = len;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic run_vec(input vec_t v);
      int cs0, rst0, t0;
      string tg;
      @(negedge clk);
      tg = tag_of(v.exp[63:56]);
      cur_rdata = v.rdata;
      cur_err   = v.err;
      cs0 = cs_total; rst0 = rst_total; t0 = cyc;
      issue(v.len, v.frame);
      chk("R10 busy after accept", 72'(busy), 72'(1));
      wait_rsp();
      chk({tg, " len"}, 72'(rsp_len), 72'(v.exp_len));
      chk({tg, " frame"}, rsp_frame, to_dut(v.exp));
      chk("R2/R3 cs count", 72'(cs_total - cs0), 72'(v.exp_cs));
      if (v.exp_cs) begin
         chk("R3 cs timing", 72'(cs_cyc), 72'(t0 + 2));
         chk("R3 addr", 72'(seen_addr), 72'(v.exp_addr));
         chk("R4 we", 72'(seen_we), 72'(v.exp_we));
         if (v.exp_we) chk("R4 wdata", 72'(seen_wdata), 72'(v.exp_wdata));
      end
      chk("R8 reset hold cycles", 72'(rst_total - rst0), 72'(v.exp_rst ? HOLD : 0));
   endtask

   initial begin
      #2000000;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      int st0, cs0;
      logic [71:0] held;
      repeat (3) @(negedge clk);
      // R1 state during reset
      chk("R1 busy", 72'(busy), 72'(0));
      chk("R1 strobes", 72'({rsp_start, dev_cs, dev_we, dev_rst}), 72'(0));
      chk("R1 rsp", {rsp_frame[67:0], rsp_len}, 72'(0));
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < 12; k++) run_vec(VECS[k]);

      // R9 response held after the strobe
      held = rsp_frame;
      @(negedge clk);
      chk("R9 strobe width", 72'(rsp_start), 72'(0));
      chk("R9 frame held", rsp_frame, held);

      // R10 second command while busy is ignored
      @(negedge clk);
      cur_rdata = 32'h0badf00d; cur_err = 1'b0;
      st0 = start_total; cs0 = cs_total;
      issue(4'd5, 72'h55_10_43_21_aa_00_00_00_00);
      issue(4'd9, 72'h55_11_ab_cd_01_02_03_04_aa);
      wait_rsp();
      chk("R10 response of first command", rsp_frame, to_dut(72'haa_7f_43_21_0b_ad_f0_0d_55));
      repeat (20) @(negedge clk);
      chk("R10 single response", 72'(start_total - st0), 72'(1));
      chk("R10 single bus cycle", 72'(cs_total - cs0), 72'(1));
      chk("R10 no write issued", 72'(seen_we), 72'(0));

      // R1 system reset during the device reset hold
      issue(4'd3, 72'h55_01_aa_00_00_00_00_00_00);
      @(negedge clk);
      chk("R1 hold started", 72'(dev_rst), 72'(1));
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 hold dropped", 72'({dev_rst, busy}), 72'(0));
      rst_n = 1'b1;
      @(negedge clk);
      run_vec(VECS[0]);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule